// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block runs single-byte read and write cycles on an external asynchronous static RAM that has 17 address bits and 8 data bits. Its system side is a plain request port. A one-cycle `req_i` pulse in idle, together with `we_i`, `addr_i` and `wdata_i`, starts a cycle. The block returns a one-cycle `done_o` when the cycle completes. After a read, the byte appears on `rdata_o`.

The memory side drives the address bus, a chip-select pair of opposite polarity, and active-low write and output strobes. It also drives write data through a separate driver-enable, so the pad ring can build the bidirectional bus. A single sequencer steps through SETUP, ACTIVE, HOLD, TURNAROUND and back to IDLE. Each phase lasts a number of clock cycles derived from a nanosecond minimum and the clock-period parameter. A write strobe is stretched if the whole write cycle would otherwise fall short of its minimum.

Top module: `sram_ctrl`

## Requirements
- R1: Out of reset and whenever the sequencer is idle, the memory is deselected: `mem_ce_n_o`=1, `mem_ce_o`=0, `mem_we_n_o`=1, `mem_oe_n_o`=1, `mem_dq_oe_o`=0 and `done_o`=0.
- R2: A strobe (`mem_we_n_o`=0 or `mem_oe_n_o`=0) only occurs while the memory is selected, meaning `mem_ce_n_o`=0 and `mem_ce_o`=1 at once.
- R3: During a write, `mem_we_n_o` stays low for exactly max(1, ceil(35/T)) cycles, stretched if needed to satisfy R4; this is 4 cycles at T=10 ns. The data driver is on, with a stable value, from SETUP until after `mem_we_n_o` rises.
- R4: For a write, the memory stays selected for SETUP+strobe+HOLD cycles, which is 6 at the defaults and is never under ceil(45/T).
- R5: During a read, `mem_oe_n_o` stays low for max(1, ceil(45/T)) cycles, 5 at the defaults, with `mem_we_n_o` high. The bus value is registered on the last of those cycles and held on `rdata_o` until the next read.
- R6: The data driver is never on while `mem_oe_n_o` is low, and the two strobes are never low together.
- R7: After `mem_oe_n_o` returns high, the data driver stays off for at least ceil(18/T) cycles, 2 at the defaults.
- R8: `done_o` is high for exactly one cycle per cycle run. It rises 1+strobe+1+ceil(18/T) cycles after the accepting edge: 8 for a write and 9 for a read at the defaults.
- R9: A request raised while a cycle is in progress is ignored. It produces no `done_o` and no memory access.
- R10: Address and write data are captured on the accepting edge. Later changes on `addr_i` or `wdata_i` do not alter the running cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start a cycle (sampled in idle) |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 17 | Byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Last read byte |
| done_o | output | 1 | One-cycle completion pulse |
| mem_addr_o | output | 17 | Memory address bus |
| mem_ce_n_o | output | 1 | Active-low chip select |
| mem_ce_o | output | 1 | Active-high chip select |
| mem_we_n_o | output | 1 | Active-low write strobe |
| mem_oe_n_o | output | 1 | Active-low output strobe |
| mem_dq_o | output | 8 | Data to memory |
| mem_dq_oe_o | output | 1 | Data driver enable |
| mem_dq_i | input | 8 | Data from memory |

## Verification
Writes go to the lowest address, the highest address and a mid-range address. Read-backs of each separate the address bits and show that the byte written is the byte returned. A read of a never-written location shows that no stray writes took place. The memory model returns garbage until the full access time has elapsed, so a read strobe that is too short, or a capture made too early, shows up as wrong data rather than passing silently. A read followed directly by a write measures the bus turnaround gap. Requests poked in mid-cycle, with altered address and data, separate a controller that holds its captured operands from one that follows its inputs or restarts.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ACTIVE,
    ST_HOLD,
    ST_TURN
  } sram_state_e;

  // cycles covering a ns minimum, never fewer than one
  function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned per);
    int unsigned c;
    c = (ns + per - 1) / per;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             last_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == '0);

endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_ctrl_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int CYC_SETUP = 1,
  parameter int CYC_WR    = 4,
  parameter int CYC_RD    = 5,
  parameter int CYC_HOLD  = 1,
  parameter int CYC_TURN  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic             last_i,
  output sram_state_e      state_o,
  output logic             wr_o,
  output logic             accept_o,
  output logic             capture_o,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic             done_o
);

  localparam logic [CNT_W-1:0] LV_SETUP = CNT_W'(CYC_SETUP - 1);
  localparam logic [CNT_W-1:0] LV_WR    = CNT_W'(CYC_WR - 1);
  localparam logic [CNT_W-1:0] LV_RD    = CNT_W'(CYC_RD - 1);
  localparam logic [CNT_W-1:0] LV_HOLD  = CNT_W'(CYC_HOLD - 1);
  localparam logic [CNT_W-1:0] LV_TURN  = CNT_W'(CYC_TURN - 1);

  sram_state_e state_q, state_d;
  logic        wr_q;
  logic        done_q;
  logic        fin;

  always_comb begin
    state_d    = state_q;
    accept_o   = 1'b0;
    capture_o  = 1'b0;
    load_o     = 1'b0;
    load_val_o = '0;
    fin        = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        state_d    = ST_SETUP;
        accept_o   = 1'b1;
        load_o     = 1'b1;
        load_val_o = LV_SETUP;
      end
      ST_SETUP: if (last_i) begin
        state_d    = ST_ACTIVE;
        load_o     = 1'b1;
        load_val_o = wr_q ? LV_WR : LV_RD;
      end
      ST_ACTIVE: if (last_i) begin
        state_d    = ST_HOLD;
        capture_o  = !wr_q;
        load_o     = 1'b1;
        load_val_o = LV_HOLD;
      end
      ST_HOLD: if (last_i) begin
        state_d    = ST_TURN;
        load_o     = 1'b1;
        load_val_o = LV_TURN;
      end
      ST_TURN: if (last_i) begin
        state_d = ST_IDLE;
        fin     = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      wr_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= fin;
      if (accept_o) wr_q <= we_i;
    end
  end

  assign state_o = state_q;
  assign wr_o    = wr_q;
  assign done_o  = done_q;

endmodule

// File: rtl/sram_pins.sv
module sram_pins
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  sram_state_e       state_i,
  input  logic              wr_i,
  input  logic              accept_i,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce_n_o,
  output logic              mem_ce_o,
  output logic              mem_we_n_o,
  output logic              mem_oe_n_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              sel;
  logic              strobe;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (accept_i) begin
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
      end
      if (capture_i) rdata_q <= mem_dq_i;
    end
  end

  // select spans SETUP..HOLD; TURN and IDLE leave the memory in standby
  assign sel    = (state_i == ST_SETUP) || (state_i == ST_ACTIVE) || (state_i == ST_HOLD);
  assign strobe = (state_i == ST_ACTIVE);

  assign mem_addr_o  = addr_q;
  assign mem_ce_n_o  = !sel;
  assign mem_ce_o    = sel;
  assign mem_we_n_o  = !(strobe && wr_i);
  assign mem_oe_n_o  = !(strobe && !wr_i);
  assign mem_dq_o    = wdata_q;
  assign mem_dq_oe_o = sel && wr_i;
  assign rdata_o     = rdata_q;

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 8,
  parameter int CLK_NS   = 10,
  parameter int T_AS_NS  = 0,
  parameter int T_PWE_NS = 35,
  parameter int T_SD_NS  = 25,
  parameter int T_AW_NS  = 35,
  parameter int T_WC_NS  = 45,
  parameter int T_AH_NS  = 0,
  parameter int T_AA_NS  = 45,
  parameter int T_OZ_NS  = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce_n_o,
  output logic              mem_ce_o,
  output logic              mem_we_n_o,
  output logic              mem_oe_n_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int CYC_SETUP = ns_to_cyc(T_AS_NS, CLK_NS);
  localparam int CYC_HOLD  = ns_to_cyc(T_AH_NS, CLK_NS);
  localparam int CYC_TURN  = ns_to_cyc(T_OZ_NS, CLK_NS);
  localparam int CYC_RD    = ns_to_cyc(T_AA_NS, CLK_NS);
  localparam int WR_BASE   = ns_to_cyc(max2(max2(T_PWE_NS, T_SD_NS), T_AW_NS), CLK_NS);
  localparam int WC_CYC    = ns_to_cyc(T_WC_NS, CLK_NS);
  // stretch the strobe when the total write cycle would be short
  localparam int CYC_WR    = (WC_CYC > CYC_SETUP + CYC_HOLD + WR_BASE)
                             ? WC_CYC - CYC_SETUP - CYC_HOLD : WR_BASE;
  localparam int MAX_CYC   = max2(max2(max2(CYC_SETUP, CYC_HOLD), max2(CYC_TURN, CYC_RD)), CYC_WR);
  localparam int CNT_W     = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

  sram_state_e      state;
  logic             wr;
  logic             accept;
  logic             capture;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             last;

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .last_o     (last)
  );

  sram_seq #(
    .CNT_W     (CNT_W),
    .CYC_SETUP (CYC_SETUP),
    .CYC_WR    (CYC_WR),
    .CYC_RD    (CYC_RD),
    .CYC_HOLD  (CYC_HOLD),
    .CYC_TURN  (CYC_TURN)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .last_i     (last),
    .state_o    (state),
    .wr_o       (wr),
    .accept_o   (accept),
    .capture_o  (capture),
    .load_o     (load),
    .load_val_o (load_val),
    .done_o     (done_o)
  );

  sram_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .state_i     (state),
    .wr_i        (wr),
    .accept_i    (accept),
    .capture_i   (capture),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .mem_dq_i    (mem_dq_i),
    .rdata_o     (rdata_o),
    .mem_addr_o  (mem_addr_o),
    .mem_ce_n_o  (mem_ce_n_o),
    .mem_ce_o    (mem_ce_o),
    .mem_we_n_o  (mem_we_n_o),
    .mem_oe_n_o  (mem_oe_n_o),
    .mem_dq_o    (mem_dq_o),
    .mem_dq_oe_o (mem_dq_oe_o)
  );

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 8,
  parameter int TURN_CYC = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              done_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_ce_n_o,
  input logic              mem_ce_o,
  input logic              mem_we_n_o,
  input logic              mem_oe_n_o,
  input logic [DATA_W-1:0] mem_dq_o,
  input logic              mem_dq_oe_o
);

  logic [7:0] oe_hi_q;

  // cycles since the output strobe last went high (saturating)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               oe_hi_q <= 8'hff;
    else if (!mem_oe_n_o)      oe_hi_q <= '0;
    else if (oe_hi_q != 8'hff) oe_hi_q <= oe_hi_q + 1'b1;
  end

  p_done_standby_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (mem_ce_n_o && !mem_ce_o && mem_we_n_o && mem_oe_n_o && !mem_dq_oe_o));

  p_strobe_selected_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_we_n_o || !mem_oe_n_o) |-> (!mem_ce_n_o && mem_ce_o));

  p_wr_driven_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_n_o |-> mem_dq_oe_o);

  p_wdata_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_dq_oe_o && $past(mem_dq_oe_o)) |-> $stable(mem_dq_o));

  p_no_contention_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_n_o |-> (!mem_dq_oe_o && mem_we_n_o));

  p_turnaround_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_dq_oe_o) |-> (int'(oe_hi_q) >= TURN_CYC));

  p_done_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_addr_held_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_ce_n_o && $past(!mem_ce_n_o)) |-> $stable(mem_addr_o));

endmodule

bind sram_ctrl sram_ctrl_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .TURN_CYC (sram_ctrl_pkg::ns_to_cyc(T_OZ_NS, CLK_NS))
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .done_o      (done_o),
  .mem_addr_o  (mem_addr_o),
  .mem_ce_n_o  (mem_ce_n_o),
  .mem_ce_o    (mem_ce_o),
  .mem_we_n_o  (mem_we_n_o),
  .mem_oe_n_o  (mem_oe_n_o),
  .mem_dq_o    (mem_dq_o),
  .mem_dq_oe_o (mem_dq_oe_o)
);

// File: tb/sram_ctrl_tb.sv
`timescale 1ns/1ps
module sram_ctrl_tb;

  localparam int AW       = 17;
  localparam int DW       = 8;
  localparam int PER      = 10;
  localparam int WR_CYC   = (35 + PER - 1) / PER;
  localparam int RD_CYC   = (45 + PER - 1) / PER;
  localparam int TURN_CYC = (18 + PER - 1) / PER;
  localparam int SPAN_MIN = (45 + PER - 1) / PER;
  localparam int WR_SPAN  = 1 + WR_CYC + 1;
  localparam int WR_LAT   = 1 + WR_CYC + 1 + TURN_CYC;
  localparam int RD_LAT   = 1 + RD_CYC + 1 + TURN_CYC;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          done;
  logic [AW-1:0] m_addr;
  logic          m_ce_n, m_ce, m_we_n, m_oe_n, m_dq_oe;
  logic [DW-1:0] m_dq_o;
  logic [DW-1:0] m_dq_i;

  always #5 clk = ~clk;

  sram_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .done_o(done), .mem_addr_o(m_addr),
    .mem_ce_n_o(m_ce_n), .mem_ce_o(m_ce), .mem_we_n_o(m_we_n), .mem_oe_n_o(m_oe_n),
    .mem_dq_o(m_dq_o), .mem_dq_oe_o(m_dq_oe), .mem_dq_i(m_dq_i)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int pending = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // memory model: data valid only after the full access time under the output strobe
  logic [DW-1:0] mem [int];
  logic [DW-1:0] ref_mem [int];
  logic [DW-1:0] rd_val = 8'h00;
  int  rd_cnt = 0;
  int  we_lo = 0, oe_lo = 0, oe_hi = 100, sel_span = 0;
  bit  prev_we_lo = 0, prev_oe_lo = 0, prev_sel = 0, prev_dq_oe = 0, span_wr = 0;
  bit  contention = 0, bad_sel = 0, we_in_rd = 0;
  logic [AW-1:0] c_addr = '0;
  logic [DW-1:0] c_data = '0;
  bit  sel;

  assign m_dq_i = (rd_cnt >= RD_CYC) ? rd_val : 8'hEE;

  always @(negedge clk) if (rst_n) begin
    sel = !m_ce_n && m_ce;
    if ((m_dq_oe && !m_oe_n) || (!m_we_n && !m_oe_n)) contention = 1;
    if ((!m_we_n || !m_oe_n) && !sel) bad_sel = 1;
    if (sel && !m_oe_n) begin
      rd_cnt++;
      rd_val = mem.exists(int'(m_addr)) ? mem[int'(m_addr)] : 8'h00;
      if (!m_we_n) we_in_rd = 1;
    end else rd_cnt = 0;
    if (prev_we_lo && m_we_n) begin
      chk(sel && m_dq_oe, "R3 data held after strobe", {sel, m_dq_oe}, 2'b11);
      chk(we_lo == WR_CYC, "R3 strobe width", we_lo, WR_CYC);
      mem[int'(m_addr)] = m_dq_o;
      c_addr = m_addr;
      c_data = m_dq_o;
    end
    if (prev_oe_lo && m_oe_n) begin
      chk(oe_lo == RD_CYC && !we_in_rd, "R5 read strobe width", oe_lo, RD_CYC);
      we_in_rd = 0;
    end
    if (prev_sel && !sel && span_wr)
      chk(sel_span == WR_SPAN && sel_span >= SPAN_MIN, "R4 write select span", sel_span, WR_SPAN);
    if (!prev_dq_oe && m_dq_oe)
      chk(oe_hi >= TURN_CYC, "R7 turnaround gap", oe_hi, TURN_CYC);
    we_lo    = !m_we_n ? we_lo + 1 : 0;
    oe_lo    = !m_oe_n ? oe_lo + 1 : 0;
    oe_hi    = !m_oe_n ? 0 : ((oe_hi < 100) ? oe_hi + 1 : oe_hi);
    if (sel && !prev_sel) span_wr = 0;
    if (sel) begin
      sel_span = prev_sel ? sel_span + 1 : 1;
      if (!m_we_n) span_wr = 1;
    end
    prev_we_lo = !m_we_n;
    prev_oe_lo = !m_oe_n;
    prev_sel   = sel;
    prev_dq_oe = m_dq_oe;
  end

  // scoreboard
  typedef struct {
    bit            wr;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    int            t;
  } item_t;
  item_t exp_q[$];
  bit prev_done = 0;

  always @(negedge clk) if (rst_n) begin
    if (done && prev_done) chk(0, "R8 done longer than one cycle", 1, 0);
    if (done && !prev_done) begin
      if (exp_q.size() == 0) begin
        chk(0, "R9 done without accepted request", 1, 0);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        chk(cyc - it.t == (it.wr ? WR_LAT : RD_LAT), "R8 done latency",
            cyc - it.t, it.wr ? WR_LAT : RD_LAT);
        chk(m_ce_n && !m_ce && !m_dq_oe, "R1 standby at done", {m_ce_n, m_ce, m_dq_oe}, 3'b100);
        if (it.wr)
          chk(c_addr == it.a && c_data == it.d, "R10 committed addr/data",
              int'({c_addr, c_data}), int'({it.a, it.d}));
        else
          chk(rdata == it.d, "R5 read data", rdata, it.d);
        pending--;
      end
    end
    prev_done = done;
  end

  task automatic op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d, input bit poke);
    item_t it;
    @(negedge clk);
    req = 1; we = wr; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    req = 0;
    it.wr = wr;
    it.a  = a;
    it.d  = wr ? d : (ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00);
    it.t  = cyc;
    if (wr) ref_mem[int'(a)] = d;
    exp_q.push_back(it);
    pending++;
    if (poke) begin
      // R9 / R10: disturb inputs and re-request mid-cycle
      addr = a ^ 17'h1; wdata = ~d; we = 1;
      @(negedge clk);
      req = 1;
      @(negedge clk);
      req = 0;
    end
    wait (pending == 0);
    @(negedge clk);
  endtask

  bit finished = 0;

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      chk(0, "watchdog", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(m_ce_n && !m_ce && m_we_n && m_oe_n && !m_dq_oe && !done, "R1 reset standby",
        {m_ce_n, m_ce, m_we_n, m_oe_n, m_dq_oe, done}, 6'b101100);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(m_ce_n && !m_ce && m_we_n && m_oe_n && !m_dq_oe && !done, "R1 idle standby",
        {m_ce_n, m_ce, m_we_n, m_oe_n, m_dq_oe, done}, 6'b101100);

    op(1, 17'h00000, 8'h3C, 0);
    op(1, 17'h1FFFF, 8'hC3, 0);
    op(1, 17'h0AAAA, 8'h55, 0);
    op(0, 17'h00000, 8'h00, 0);
    op(0, 17'h1FFFF, 8'h00, 0);
    op(0, 17'h0AAAA, 8'h00, 0);
    op(0, 17'h12345, 8'h00, 0);
    // read directly followed by write: turnaround
    op(0, 17'h0AAAA, 8'h00, 0);
    op(1, 17'h0AAAA, 8'hA5, 1);
    op(0, 17'h0AAAB, 8'h00, 0);  // R9: poked write must not land
    op(0, 17'h0AAAA, 8'h00, 0);
    op(0, 17'h00000, 8'h00, 1);  // R10: read keeps its captured address
    op(0, 17'h00001, 8'h00, 0);  // R9: poked request ignored
    chk(rdata == 8'h00, "R5 rdata held after read", rdata, 8'h00);
    repeat (4) @(negedge clk);
    chk(rdata == 8'h00 && !done, "R9 no activity while idle", {rdata, done}, 0);

    chk(!contention, "R6 driver vs output strobe", contention, 0);
    chk(!bad_sel, "R2 strobe outside select", bad_sel, 0);
    chk(pending == 0, "R8 all cycles completed", pending, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule